// File: doc/BRIEF.md
# Sliding-Window Rank Selector

This block keeps the most recent TAP magnitude samples of a stream and, after each new sample, points to the window entry that holds a requested rank. Rank 0 is the smallest sample, rank TAP-1 the largest, and the median lies in between. The block does not return the sample itself. It returns a window address. A neighbouring store, which keeps the full pixel words in the same order of arrival, uses that address to fetch the selected pixel.

The block never sorts the window. When a sample arrives it is compared once with every sample that stays in the window. Each entry keeps a row of "smaller than me" flags, and these flags move with the entry as the window slides. Each entry also keeps a running count of those flags. Per accepted sample, an older entry's count changes only by the flag of the departing oldest sample and the flag of the arriving sample. The count of the newest entry is summed from its fresh flags. The entry whose count equals the requested rank is encoded into the address.

Input and output are valid/ready streams with a single stage between them. A new sample is taken when `in_valid` and `in_ready` are both high. Once the window is full, each accepted sample produces one output, which is held until `out_ready` is high. While an output waits, `in_ready` is low. The `rank` pin is plain control. It is read combinationally, so it should be held steady while `out_valid` is high and the output has not yet been taken.

Top module: `rank_filter_core`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: `out_valid` stays 0 until TAP samples have been accepted since reset.
- R3: The window addresses run from 0, the oldest entry, to TAP-1, the sample accepted last. Address a holds the sample accepted TAP-1-a acceptances before the newest one.
- R4: `out_addr` is the window address whose rank index equals `rank`. A sample's rank index is the number of window samples that are smaller than it.
- R5: Samples of equal value are ranked by age: the older sample takes the lower index. For example, a window of identical samples gives `out_addr` equal to `rank`.
- R6: A `rank` value above TAP-1 selects rank TAP-1, which is the largest sample.
- R7: Each accepted sample slides the window by one entry and discards the oldest entry. No other change is made to the window.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, the offered sample is not taken, and `out_valid` and the window stay unchanged.
- R9: Once the window is full, each accepted sample yields exactly one output. `out_valid` falls after a transfer when no new sample is accepted in the same cycle.
- R10: When the window is full, exactly one entry matches any rank. Every kept count equals the number of flags set in its row.
- R11: `out_addr` follows the current `rank` with no added cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | New sample offered |
| in_ready | output | 1 | Block can take the offered sample |
| in_sample | input | DW | Magnitude of the new sample |
| rank | input | CW | Requested rank, 0 = smallest |
| out_valid | output | 1 | Address of the current window is ready |
| out_ready | input | 1 | Consumer takes the address |
| out_addr | output | CW | Window address of the ranked sample |

## Verification
Ascending and descending ramps place the wanted sample at opposite ends of the window, so a reversed comparison or a misplaced flag gives a different address. A window of identical values can only be resolved by the age rule, and random samples drawn from a narrow range mix ties with distinct values. Random samples across the full range test the count bookkeeping over many slides. Every rank is swept on every window, out-of-range ranks included. A stalled consumer is used to show that the window holds still under back-pressure.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_TAP_DEFAULT = 9;
  localparam int RF_DW_DEFAULT  = 10;
endpackage

// File: rtl/rf_cmp_bank.sv
module rf_cmp_bank #(
  parameter int TAP = rf_pkg::RF_TAP_DEFAULT,
  parameter int DW  = rf_pkg::RF_DW_DEFAULT
) (
  input  logic [DW-1:0]     new_s,
  input  logic [TAP*DW-1:0] win_flat,
  output logic [TAP-2:0]    lt
);
  // lt[j]: arriving sample is strictly below the sample that moves into slot j
  for (genvar j = 0; j < TAP - 1; j++) begin : g_cmp
    assign lt[j] = new_s < win_flat[(j+1)*DW +: DW];
  end
endmodule

// File: rtl/rf_window.sv
module rf_window #(
  parameter int TAP = rf_pkg::RF_TAP_DEFAULT,
  parameter int DW  = rf_pkg::RF_DW_DEFAULT,
  parameter int CW  = $clog2(TAP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift,
  input  logic [DW-1:0]     new_s,
  input  logic [TAP-2:0]    lt,
  output logic [TAP*DW-1:0] win_flat,
  output logic [TAP*CW-1:0] cnt_flat
);
  logic [DW-1:0]  dat [TAP];
  logic [TAP-1:0] row [TAP];
  logic [CW-1:0]  cnt [TAP];
  logic [CW-1:0]  new_cnt;

  // count of the newest entry: full sum of its fresh flags
  always_comb begin
    new_cnt = '0;
    for (int i = 0; i < TAP - 1; i++) new_cnt = new_cnt + CW'(!lt[i]);
  end

  for (genvar j = 0; j < TAP - 1; j++) begin : g_old
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dat[j] <= '0;
        row[j] <= '0;
        cnt[j] <= '0;
      end else if (shift) begin
        dat[j] <= dat[j+1];
        row[j] <= {lt[j], row[j+1][TAP-1:1]};
        cnt[j] <= cnt[j+1] - CW'(row[j+1][0]) + CW'(lt[j]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat[TAP-1] <= '0;
      row[TAP-1] <= '0;
      cnt[TAP-1] <= '0;
    end else if (shift) begin
      dat[TAP-1] <= new_s;
      row[TAP-1] <= {1'b0, ~lt};
      cnt[TAP-1] <= new_cnt;
    end
  end

  for (genvar j = 0; j < TAP; j++) begin : g_out
    assign win_flat[j*DW +: DW] = dat[j];
    assign cnt_flat[j*CW +: CW] = cnt[j];

    // R10
    cnt_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt[j]) == $countones(row[j]));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cnt[j]) < TAP);
  end
endmodule

// File: rtl/rf_select.sv
module rf_select #(
  parameter int TAP = rf_pkg::RF_TAP_DEFAULT,
  parameter int CW  = $clog2(TAP)
) (
  input  logic [TAP*CW-1:0] cnt_flat,
  input  logic [CW-1:0]     rank,
  output logic [TAP-1:0]    hit,
  output logic [CW-1:0]     addr
);
  localparam logic [CW-1:0] TOP_RANK = CW'(TAP - 1);
  logic [CW-1:0] rk;

  assign rk = (rank > TOP_RANK) ? TOP_RANK : rank;

  for (genvar j = 0; j < TAP; j++) begin : g_hit
    assign hit[j] = cnt_flat[j*CW +: CW] == rk;
  end

  always_comb begin
    addr = '0;
    for (int j = 0; j < TAP; j++) if (hit[j]) addr = addr | CW'(j);
  end
endmodule

// File: rtl/rank_filter_core.sv
module rank_filter_core #(
  parameter int TAP = rf_pkg::RF_TAP_DEFAULT,
  parameter int DW  = rf_pkg::RF_DW_DEFAULT,
  parameter int CW  = $clog2(TAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_sample,
  input  logic [CW-1:0] rank,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_addr
);
  localparam int FW = $clog2(TAP + 1);

  logic [TAP-2:0]    lt;
  logic [TAP*DW-1:0] win_flat;
  logic [TAP*CW-1:0] cnt_flat;
  logic [TAP-1:0]    hit;
  logic [FW-1:0]     fill;
  logic              full, pend, take_in, take_out;

  assign full      = fill == FW'(TAP);
  assign out_valid = full && pend;
  assign in_ready  = !out_valid || out_ready;
  assign take_in   = in_valid && in_ready;
  assign take_out  = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      pend <= 1'b0;
    end else begin
      if (take_in && !full) fill <= fill + FW'(1);
      if (take_in)       pend <= 1'b1;
      else if (take_out) pend <= 1'b0;
    end
  end

  rf_cmp_bank #(.TAP(TAP), .DW(DW)) u_cmp (
    .new_s(in_sample), .win_flat(win_flat), .lt(lt)
  );

  rf_window #(.TAP(TAP), .DW(DW), .CW(CW)) u_win (
    .clk(clk), .rst_n(rst_n), .shift(take_in), .new_s(in_sample),
    .lt(lt), .win_flat(win_flat), .cnt_flat(cnt_flat)
  );

  rf_select #(.TAP(TAP), .CW(CW)) u_sel (
    .cnt_flat(cnt_flat), .rank(rank), .hit(hit), .addr(out_addr)
  );

  // R10
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> $countones(hit) == 1);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(win_flat));
  // R9
  out_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
  // R2
  no_early_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> fill == FW'(TAP));
endmodule

// File: tb/rank_filter_core_tb.sv
module rank_filter_core_tb;
  localparam int TAP = 9;
  localparam int DW  = 10;
  localparam int CW  = $clog2(TAP);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_sample = '0;
  logic [CW-1:0] rank = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [CW-1:0] out_addr;

  int total = 0;
  int bad = 0;
  int fill = 0;
  int mw [TAP];
  bit done = 0;

  always #5 clk = ~clk;

  rank_filter_core #(.TAP(TAP), .DW(DW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .rank(rank), .out_valid(out_valid),
    .out_ready(out_ready), .out_addr(out_addr)
  );

  function automatic int exp_addr(int r);
    int rr = (r > TAP - 1) ? TAP - 1 : r;
    for (int j = 0; j < TAP; j++) begin
      int c = 0;
      for (int i = 0; i < TAP; i++)
        if (mw[i] < mw[j] || (mw[i] == mw[j] && i < j)) c++;
      if (c == rr) return j;
    end
    return -1;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_shift(int s);
    for (int i = 0; i < TAP - 1; i++) mw[i] = mw[i+1];
    mw[TAP-1] = s;
    if (fill < TAP) fill++;
  endtask

  // offer one sample at a point away from the edge, accept it at the next edge
  task automatic send(int s);
    in_valid = 1'b1;
    in_sample = DW'(s);
    @(posedge clk);
    #1 in_valid = 1'b0;
    model_shift(s);
    chk(fill >= TAP ? "R9 out_valid after sample" : "R2 out_valid while filling",
        int'(out_valid), fill >= TAP ? 1 : 0);
  endtask

  // sweep every rank on the current window (R4 R5 R6 R11)
  task automatic sweep(string req);
    for (int r = 0; r < (1 << CW); r++) begin
      rank = CW'(r);
      @(negedge clk);
      chk(r > TAP - 1 ? "R6 clamp" : req, int'(out_addr), exp_addr(r));
    end
    chk("R9 out_valid drops after transfer", int'(out_valid), 0);
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < TAP; i++) mw[i] = 0;
    #12;
    // R1
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: identical samples, ties ranked by age
    for (int i = 0; i < TAP; i++) send(37);
    sweep("R5 ties");
    // R3 R4: ascending ramp, address equals rank
    for (int i = 0; i < TAP; i++) begin send(100 + 3 * i); sweep("R3 ascending"); end
    // R4: descending ramp
    for (int i = 0; i < TAP; i++) begin send(900 - 7 * i); sweep("R4 descending"); end
    // R7: extremes slide out
    send(0); sweep("R7 min enters");
    send((1 << DW) - 1); sweep("R7 max enters");

    // R8: stalled consumer
    out_ready = 1'b0;
    send(512);
    in_valid = 1'b1;
    in_sample = DW'(3);
    #1 chk("R8 in_ready low", int'(in_ready), 0);
    @(posedge clk);
    #1 chk("R8 out_valid held", int'(out_valid), 1);
    for (int r = 0; r < 3; r++) begin
      rank = CW'(r * 4);
      #1 chk("R8 window unchanged", int'(out_addr), exp_addr(r * 4));
    end
    out_ready = 1'b1;
    #1 chk("R8 in_ready after release", int'(in_ready), 1);
    @(posedge clk);
    #1 in_valid = 1'b0;
    model_shift(3);
    chk("R9 new output after release", int'(out_valid), 1);
    sweep("R7 after stall");

    // R4 R5: narrow random range, many ties
    for (int n = 0; n < 120; n++) begin
      send(int'($urandom_range(0, 3)));
      sweep("R5 random ties");
    end
    // R4 R10: full random range
    for (int n = 0; n < 200; n++) begin
      send(int'($urandom_range(0, (1 << DW) - 1)));
      sweep("R4 random");
    end

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule